// File: doc/BRIEF.md
# Sixteen-Bit Up-Counter with Clear-on-Compare

This block is a 16-bit up-counter that advances on each system clock cycle in which a timer clock enable is high. A 4-bit mode field picks how the count behaves. In free-running mode the count climbs to all-ones and rolls over to zero. In clear-on-compare mode the count returns to zero on the tick after it equals a top value. The top value comes from compare register A or from the capture register, depending on the mode code.

Software can load the count at any time. Three sticky flags record events: overflow, a top match taken from register A, and a top match taken from the capture register. Each flag has its own clear strobe, where writing a one clears the flag. The block also drives single-cycle match pulses that output-compare logic next to it can use.

Top module: `ctc_timer`

## Requirements
- R1: While rstN is low, count is 0x0000 and ovfFlag, cmpAFlag and capFlag are all 0.
- R2: When cntWrEn is low, count rises by exactly one at each clock edge where tickEn is high, and holds its value at each edge where tickEn is low.
- R3: With modeSel = 0, count goes from 0xFFFF to 0x0000 on a tick and is never cleared by equality with cmpA or capTop.
- R4: ovfFlag becomes 1 at the same clock edge where an advancing tick takes count from 0xFFFF to 0x0000. It then stays 1 until ovfClr is applied.
- R5: With modeSel = 4, an advancing tick while count equals cmpA loads 0x0000 and sets cmpAFlag at that same edge. capFlag is not set.
- R6: With modeSel = 12, an advancing tick while count equals capTop loads 0x0000 and sets capFlag at that same edge. cmpAFlag is not set, and equality with cmpA does not clear the count.
- R7: When cntWrEn is high, count takes cntWrData at the next edge whatever tickEn is. That cycle neither advances the count nor sets any flag.
- R8: Every modeSel value other than 4 and 12 behaves exactly like modeSel = 0.
- R9: A high ovfClr, cmpAClr or capClr clears only its own flag at the next edge. If that flag's set event happens in the same cycle, the flag stays 1.
- R10: matchA is high in a cycle exactly when tickEn is high, cntWrEn is low and count equals cmpA, in any mode. topMatch is high in a cycle exactly when the same advancing tick meets count equal to the active top value in mode 4 or 12.
- R11: In mode 4 or 12, a count loaded above the top value keeps counting up to 0xFFFF, then rolls over to 0x0000 and sets ovfFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer clock enable; the count advances only when this is high |
| modeSel | input | 4 | Mode code: 0 free-running, 4 clear on cmpA, 12 clear on capTop |
| cntWrEn | input | 1 | Software load strobe for the count |
| cntWrData | input | 16 | Value loaded into the count |
| cmpA | input | 16 | Compare register A |
| capTop | input | 16 | Capture register, used as the top value in mode 12 |
| ovfClr | input | 1 | Write-one-to-clear strobe for ovfFlag |
| cmpAClr | input | 1 | Write-one-to-clear strobe for cmpAFlag |
| capClr | input | 1 | Write-one-to-clear strobe for capFlag |
| count | output | 16 | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpAFlag | output | 1 | Sticky top-match flag for register A |
| capFlag | output | 1 | Sticky top-match flag for the capture register |
| matchA | output | 1 | Pulse: an advancing tick meets count equal to cmpA |
| topMatch | output | 1 | Pulse: an advancing tick meets the active top value |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a 4-bit mode field and mode codes 0, 4 and 12. With those values it exercises the real all-ones rollover and the real mode decode. Software loads of values next to 0xFFFF or next to a small top value reach rollover and top-match within a few ticks, with no need for tens of thousands of cycles. Codes 5 and 15 cover the unsupported-mode fallback. Small top values such as 2 and 3 keep each clear-on-compare period short enough to check cycle by cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Strobes that the control sends to the datapath each cycle
  typedef struct packed {
    logic load;      // software load of the count
    logic advance;   // count moves this cycle
    logic clearTop;  // the move goes to zero instead of +1
  } tmrStrobe_t;

  // Comparison results that the datapath returns to the control
  typedef struct packed {
    logic atMax;
    logic eqA;
    logic eqCap;
  } tmrCmp_t;

  // Source of the top value
  typedef enum logic [1:0] {
    TOP_NONE = 2'd0,
    TOP_REGA = 2'd1,
    TOP_CAP  = 2'd2
  } topSrc_e;

  // Flag slots
  localparam int FLAG_N   = 3;
  localparam int FLG_OVF  = 0;
  localparam int FLG_A    = 1;
  localparam int FLG_CAP  = 2;

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] capTop,
  output logic [CNT_W-1:0] count,
  output tmrCmp_t          cmp
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countNext;

  always_comb begin
    cmp.atMax = &countQ;
    cmp.eqA   = (countQ == cmpA);
    cmp.eqCap = (countQ == capTop);
  end

  always_comb begin
    countNext = countQ;
    if (strobe.load) begin
      countNext = wrData;
    end else if (strobe.advance) begin
      countNext = strobe.clearTop ? CNT_ZERO : (countQ + CNT_ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= CNT_ZERO;
    else       countQ <= countNext;
  end

  assign count = countQ;

  // R7: a load lands exactly the written value
  p_load_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> countQ == $past(wrData));

  // R2: an advance without clear is an increment of one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clearTop && !strobe.load) |=> countQ == $past(countQ) + CNT_ONE);

  // R2: no load and no advance leaves the count alone
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.load) |=> $stable(countQ));

  // R5: a clear on top lands at zero
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.clearTop && !strobe.load) |=> countQ == CNT_ZERO);

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int                  MODE_W       = 4,
  parameter logic [MODE_W-1:0]   MODE_CTC_A   = MODE_W'(4),
  parameter logic [MODE_W-1:0]   MODE_CTC_CAP = MODE_W'(12)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cntWrEn,
  input  logic [MODE_W-1:0] modeSel,
  input  tmrCmp_t           cmp,
  input  logic              ovfClr,
  input  logic              cmpAClr,
  input  logic              capClr,
  output tmrStrobe_t        strobe,
  output logic              ovfFlag,
  output logic              cmpAFlag,
  output logic              capFlag,
  output logic              matchA,
  output logic              topMatch
);

  topSrc_e           topSrc;
  logic              advance;
  logic              topEq;
  logic [FLAG_N-1:0] setVec;
  logic [FLAG_N-1:0] clrVec;
  logic [FLAG_N-1:0] flagQ;

  // Mode decode: any code that is not a clear-on-compare code runs free
  always_comb begin
    if (modeSel == MODE_CTC_A)        topSrc = TOP_REGA;
    else if (modeSel == MODE_CTC_CAP) topSrc = TOP_CAP;
    else                              topSrc = TOP_NONE;
  end

  always_comb begin
    unique case (topSrc)
      TOP_REGA: topEq = cmp.eqA;
      TOP_CAP:  topEq = cmp.eqCap;
      default:  topEq = 1'b0;
    endcase
  end

  // A software load wins over the tick
  assign advance = tickEn & ~cntWrEn;

  always_comb begin
    strobe.load     = cntWrEn;
    strobe.advance  = advance;
    strobe.clearTop = topEq;
  end

  always_comb begin
    setVec[FLG_OVF] = advance & cmp.atMax;
    setVec[FLG_A]   = advance & topEq & (topSrc == TOP_REGA);
    setVec[FLG_CAP] = advance & topEq & (topSrc == TOP_CAP);
    clrVec[FLG_OVF] = ovfClr;
    clrVec[FLG_A]   = cmpAClr;
    clrVec[FLG_CAP] = capClr;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic flagR;
    always_ff @(posedge clk) begin
      if (!rstN) flagR <= 1'b0;
      else       flagR <= setVec[i] | (flagR & ~clrVec[i]);
    end
    assign flagQ[i] = flagR;

    // R9: a flag with no clear strobe stays set
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      (flagR && !clrVec[i]) |=> flagR);

    // R9: set and clear together leave the flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      (setVec[i] && clrVec[i]) |=> flagR);

    // R9: clear alone empties the flag
    p_clear_only_r9: assert property (@(posedge clk) disable iff (!rstN)
      (clrVec[i] && !setVec[i]) |=> !flagR);
  end

  assign ovfFlag  = flagQ[FLG_OVF];
  assign cmpAFlag = flagQ[FLG_A];
  assign capFlag  = flagQ[FLG_CAP];

  assign matchA   = advance & cmp.eqA;
  assign topMatch = advance & topEq;

  // R4: rollover raises the overflow flag at that same edge
  p_ovf_on_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (advance && cmp.atMax) |=> ovfFlag);

  // R3, R8: free-running codes never clear on compare
  p_no_clear_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != MODE_CTC_A && modeSel != MODE_CTC_CAP) |-> !strobe.clearTop);

  // R7: a load cycle raises no flag
  p_load_no_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |-> (setVec == '0));

  // R10: pulses appear only on an advancing tick
  p_pulse_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (matchA || topMatch) |-> (tickEn && !cntWrEn));

endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
  import tmr_pkg::*;
#(
  parameter int                CNT_W        = 16,
  parameter int                MODE_W       = 4,
  parameter logic [MODE_W-1:0] MODE_CTC_A   = MODE_W'(4),
  parameter logic [MODE_W-1:0] MODE_CTC_CAP = MODE_W'(12)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic [CNT_W-1:0]  cmpA,
  input  logic [CNT_W-1:0]  capTop,
  input  logic              ovfClr,
  input  logic              cmpAClr,
  input  logic              capClr,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              cmpAFlag,
  output logic              capFlag,
  output logic              matchA,
  output logic              topMatch
);

  tmrStrobe_t strobe;
  tmrCmp_t    cmp;

  tmr_ctrl #(
    .MODE_W      (MODE_W),
    .MODE_CTC_A  (MODE_CTC_A),
    .MODE_CTC_CAP(MODE_CTC_CAP)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .cntWrEn (cntWrEn),
    .modeSel (modeSel),
    .cmp     (cmp),
    .ovfClr  (ovfClr),
    .cmpAClr (cmpAClr),
    .capClr  (capClr),
    .strobe  (strobe),
    .ovfFlag (ovfFlag),
    .cmpAFlag(cmpAFlag),
    .capFlag (capFlag),
    .matchA  (matchA),
    .topMatch(topMatch)
  );

  tmr_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(cntWrData),
    .cmpA  (cmpA),
    .capTop(capTop),
    .count (count),
    .cmp   (cmp)
  );

  // R1: reset leaves a zero count and empty flags
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (count == '0 && !ovfFlag && !cmpAFlag && !capFlag) || !rstN);

endmodule

// File: tb/tb_ctc_timer.sv
`timescale 1ns/1ps
module tb_ctc_timer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic [3:0]  modeSel;
  logic        cntWrEn;
  logic [15:0] cntWrData;
  logic [15:0] cmpA;
  logic [15:0] capTop;
  logic        ovfClr, cmpAClr, capClr;
  logic [15:0] count;
  logic        ovfFlag, cmpAFlag, capFlag, matchA, topMatch;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ctc_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modeSel(modeSel),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cmpA(cmpA), .capTop(capTop),
    .ovfClr(ovfClr), .cmpAClr(cmpAClr), .capClr(capClr),
    .count(count), .ovfFlag(ovfFlag), .cmpAFlag(cmpAFlag), .capFlag(capFlag),
    .matchA(matchA), .topMatch(topMatch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] v);
    cntWrEn = 1'b1; cntWrData = v;
    cyc();
    cntWrEn = 1'b0;
  endtask

  task automatic tick1();
    tickEn = 1'b1;
    cyc();
    tickEn = 1'b0;
  endtask

  task automatic clrAll();
    ovfClr = 1'b1; cmpAClr = 1'b1; capClr = 1'b1;
    cyc();
    ovfClr = 1'b0; cmpAClr = 1'b0; capClr = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; tickEn = 1'b1; modeSel = 4'd0; cntWrEn = 1'b0; cntWrData = 16'h0;
    cmpA = 16'h0; capTop = 16'h0; ovfClr = 1'b0; cmpAClr = 1'b0; capClr = 1'b0;
    cyc(); cyc();
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 flags", {29'd0, ovfFlag, cmpAFlag, capFlag}, 32'h0);
    tickEn = 1'b0;
    rstN = 1'b1;
    cyc();
  endtask

  task automatic t_gating();
    modeSel = 4'd0; cmpA = 16'h0100;
    wr(16'd10);
    for (int i = 0; i < 3; i++) cyc();
    chk("R2 hold without tick", 32'(count), 32'd10);
    tick1();
    chk("R2 single tick", 32'(count), 32'd11);
    for (int i = 0; i < 4; i++) begin
      tickEn = (i % 2 == 0);
      cyc();
    end
    tickEn = 1'b0;
    chk("R2 alternating ticks", 32'(count), 32'd13);
  endtask

  task automatic t_wrap();
    modeSel = 4'd0; cmpA = 16'd5; capTop = 16'd5;
    clrAll();
    wr(16'hFFFE);
    tick1();
    chk("R3 at max", 32'(count), 32'hFFFF);
    chk("R4 no early ovf", 32'(ovfFlag), 32'd0);
    tick1();
    chk("R3 rollover", 32'(count), 32'h0);
    chk("R4 ovf same edge", 32'(ovfFlag), 32'd1);
    for (int i = 0; i < 6; i++) tick1();
    chk("R3 no clear on cmpA", 32'(count), 32'd6);
    chk("R4 ovf sticky", 32'(ovfFlag), 32'd1);
    chk("R3 no match flags", {30'd0, cmpAFlag, capFlag}, 32'd0);
    cmpAClr = 1'b1; capClr = 1'b1;
    cyc();
    cmpAClr = 1'b0; capClr = 1'b0;
    chk("R9 other clears leave ovf", 32'(ovfFlag), 32'd1);
    ovfClr = 1'b1;
    cyc();
    ovfClr = 1'b0;
    chk("R9 ovf cleared", 32'(ovfFlag), 32'd0);
  endtask

  task automatic t_ctcA();
    modeSel = 4'd4; cmpA = 16'd3; capTop = 16'd1;
    clrAll();
    wr(16'd0);
    for (int i = 0; i < 3; i++) begin
      tickEn = 1'b1;
      #1;
      chk("R10 no matchA early", 32'(matchA), 32'd0);
      cyc();
      chk("R5 count up", 32'(count), 32'(i + 1));
    end
    chk("R5 capTop ignored", 32'(capFlag), 32'd0);
    #1;
    chk("R10 matchA at top", 32'(matchA), 32'd1);
    chk("R10 topMatch at top", 32'(topMatch), 32'd1);
    cyc();
    tickEn = 1'b0;
    chk("R5 cleared to zero", 32'(count), 32'd0);
    chk("R5 cmpAFlag set", 32'(cmpAFlag), 32'd1);
    chk("R5 capFlag clear", 32'(capFlag), 32'd0);
    chk("R5 no ovf", 32'(ovfFlag), 32'd0);
    #1;
    chk("R10 no pulse without tick", 32'({matchA, topMatch}), 32'd0);
  endtask

  task automatic t_ctcCap();
    modeSel = 4'd12; capTop = 16'd2; cmpA = 16'd1;
    clrAll();
    wr(16'd0);
    tickEn = 1'b1;
    #1;
    chk("R10 topMatch low below top", 32'(topMatch), 32'd0);
    cyc();
    #1;
    chk("R10 matchA any mode", 32'(matchA), 32'd1);
    chk("R10 topMatch not on cmpA", 32'(topMatch), 32'd0);
    cyc();
    chk("R6 no clear on cmpA", 32'(count), 32'd2);
    chk("R6 cmpAFlag stays", 32'(cmpAFlag), 32'd0);
    cyc();
    tickEn = 1'b0;
    chk("R6 cleared at capTop", 32'(count), 32'd0);
    chk("R6 capFlag set", 32'(capFlag), 32'd1);
    chk("R6 cmpAFlag clear", 32'(cmpAFlag), 32'd0);
  endtask

  task automatic t_write();
    modeSel = 4'd4; cmpA = 16'd3;
    clrAll();
    wr(16'd3);
    tickEn = 1'b1; cntWrEn = 1'b1; cntWrData = 16'd7;
    #1;
    chk("R7 no pulse on load", 32'({matchA, topMatch}), 32'd0);
    cyc();
    tickEn = 1'b0; cntWrEn = 1'b0;
    chk("R7 load wins", 32'(count), 32'd7);
    chk("R7 no flag on load", 32'(cmpAFlag), 32'd0);
    tick1();
    chk("R11 above top counts up", 32'(count), 32'd8);
    wr(16'hFFFF);
    tick1();
    chk("R11 wraps above top", 32'(count), 32'd0);
    chk("R11 ovf set", 32'(ovfFlag), 32'd1);
    chk("R11 no top flag", 32'(cmpAFlag), 32'd0);
  endtask

  task automatic t_badmode();
    cmpA = 16'd3; capTop = 16'd3;
    clrAll();
    modeSel = 4'd5;
    wr(16'd3);
    tick1();
    chk("R8 mode 5 no clear", 32'(count), 32'd4);
    modeSel = 4'd15;
    wr(16'd3);
    tick1();
    chk("R8 mode 15 no clear", 32'(count), 32'd4);
    chk("R8 no match flags", {30'd0, cmpAFlag, capFlag}, 32'd0);
    wr(16'hFFFF);
    tick1();
    chk("R8 mode 15 wraps", 32'(count), 32'd0);
    chk("R8 mode 15 ovf", 32'(ovfFlag), 32'd1);
  endtask

  task automatic t_setWins();
    modeSel = 4'd4; cmpA = 16'd2;
    clrAll();
    wr(16'd2);
    tick1();
    chk("R9 flag set first", 32'(cmpAFlag), 32'd1);
    wr(16'd2);
    tickEn = 1'b1; cmpAClr = 1'b1;
    cyc();
    tickEn = 1'b0; cmpAClr = 1'b0;
    chk("R9 set wins over clear", 32'(cmpAFlag), 32'd1);
    ovfClr = 1'b1; capClr = 1'b1;
    cyc();
    ovfClr = 1'b0; capClr = 1'b0;
    chk("R9 other clears leave cmpAFlag", 32'(cmpAFlag), 32'd1);
    cmpAClr = 1'b1;
    cyc();
    cmpAClr = 1'b0;
    chk("R9 cmpAFlag cleared", 32'(cmpAFlag), 32'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_gating();
    t_wrap();
    t_ctcA();
    t_ctcCap();
    t_write();
    t_badmode();
    t_setWins();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule